// File: doc/BRIEF.md
# Periodic Interval Timer

This block produces a steady time base for a processor subsystem. A fixed divide-by-16 prescaler turns the main clock into slow ticks. A 20-bit period counter advances once per tick and wraps back to zero after a programmed number of ticks. Each wrap adds one to a 12-bit period-overflow count and sets a sticky status flag. The flag can also drive a level interrupt. Software reads one packed word holding both the overflow count and the current count, so it can rebuild elapsed time even when it was late in servicing a period.

Two addresses return the packed word. Reading the acknowledge view clears the overflow count and the flag. Reading the snapshot view has no side effect. When the run bit is turned off, the counter does not stop at once: it finishes the period in progress, lands on zero and parks there. The bus is a simple single-cycle strobe interface with 32-bit words and registered read data.

Top module: `interval_timer`

## Requirements
- R1: After a synchronous reset, the control word, the count, the overflow count, the status flag and the interrupt output are all zero.
- R2: While running, the count advances by exactly one for every 16 clock cycles, and it does not change between ticks.
- R3: On a tick where the count is at or above the interval limit, the count returns to 0, the overflow count adds one modulo 4096, and the status flag is set. A limit of L therefore gives a period of L+1 ticks.
- R4: Both the acknowledge view and the snapshot view return the overflow count in bits 31:20 and the current count in bits 19:0.
- R5: A read of the acknowledge view clears the overflow count and the status flag. If a wrap happens in the same cycle, the wrap wins: the overflow count becomes 1 and the flag stays set.
- R6: A read of the snapshot view leaves the overflow count and the status flag unchanged.
- R7: A read of the status word returns the flag in bit 0 and zeros in every other bit.
- R8: When the run bit is cleared with a nonzero count, the counter keeps ticking against the last limit it ran with. It wraps to 0 (counting that wrap as a normal wrap) and then holds at 0 until the run bit is set again.
- R9: The interrupt output equals the status flag AND the interrupt-enable bit. Counting and flag setting do not depend on the interrupt-enable bit.
- R10: Word offsets are decoded from address bits 3:2: 0x0 control, 0x4 status, 0x8 acknowledge view, 0xC snapshot view. The control word keeps the limit in bits 19:0, the run bit at bit 24 and the interrupt-enable bit at bit 25, and reads back with all other bits zero. Writes to offsets 0x4, 0x8 and 0xC change nothing, and a write to 0x8 does not clear anything.
- R11: Read data appears on the clock edge that samples the read strobe, and it holds its value until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Access strobe for one cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Byte address of the word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq | output | 1 | Level interrupt: flag AND interrupt enable |

## Verification
The hardest case to reach is an acknowledge read that lands on the same cycle as a period wrap. That read must return the pre-wrap word, while the wrap must still survive the clear. To force it, the bench sets the limit to 0, so every tick is a wrap, and then issues acknowledge reads on every consecutive cycle. This sweeps all 16 prescaler phases, so several reads coincide with a wrap. A second hard case is the wind-down after the run bit is cleared. The bench clears the run bit in the middle of a long period and then watches the counter park through the snapshot view. Random control writes, idle gaps and reads are then checked against a cycle model built from the requirements.

// File: rtl/pit_pkg.sv
package pit_pkg;
  typedef enum logic [1:0] {
    REG_CTRL = 2'd0,
    REG_STAT = 2'd1,
    REG_ACKV = 2'd2,
    REG_SNAP = 2'd3
  } reg_sel_e;

  localparam int RUN_BIT   = 24;
  localparam int IRQEN_BIT = 25;
endpackage

// File: rtl/pit_prescaler.sv
module pit_prescaler #(
  parameter int DIV = 16
) (
  input  logic clk,
  input  logic rst,
  output logic tick_o
);
  generate
    if (DIV < 2) begin : g_bypass
      assign tick_o = 1'b1;
    end else begin : g_div
      localparam int W = $clog2(DIV);
      logic [W-1:0] phase_q;

      assign tick_o = (phase_q == W'(DIV - 1));

      always_ff @(posedge clk) begin
        if (rst)         phase_q <= '0;
        else if (tick_o) phase_q <= '0;
        else             phase_q <= phase_q + 1'b1;
      end

      // R2: a tick is never followed by another tick on the next cycle
      assert_tick_gap_R2: assert property (@(posedge clk) disable iff (rst)
        tick_o |=> !tick_o);
    end
  endgenerate
endmodule

// File: rtl/pit_counter.sv
module pit_counter #(
  parameter int CNT_W = 20,
  parameter int OVF_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_i,
  input  logic             run_i,
  input  logic [CNT_W-1:0] limit_i,
  input  logic             clr_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [OVF_W-1:0] ovf_o,
  output logic             flag_o
);
  logic [CNT_W-1:0] cnt_q, held_lim_q, eff_lim;
  logic [OVF_W-1:0] ovf_q;
  logic             flag_q, active, wrap_ev;

  always_comb begin
    eff_lim = run_i ? limit_i : held_lim_q;
    active  = run_i || (cnt_q != '0);
    wrap_ev = tick_i && active && (cnt_q >= eff_lim);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q      <= '0;
      held_lim_q <= '0;
      ovf_q      <= '0;
      flag_q     <= 1'b0;
    end else begin
      if (run_i) held_lim_q <= limit_i;
      if (tick_i && active) cnt_q <= wrap_ev ? '0 : cnt_q + 1'b1;
      if (clr_i)        ovf_q <= wrap_ev ? OVF_W'(1) : '0;
      else if (wrap_ev) ovf_q <= ovf_q + 1'b1;
      if (wrap_ev)      flag_q <= 1'b1;
      else if (clr_i)   flag_q <= 1'b0;
    end
  end

  assign cnt_o  = cnt_q;
  assign ovf_o  = ovf_q;
  assign flag_o = flag_q;

  // R2: without a tick the count is frozen
  assert_cnt_still_R2: assert property (@(posedge clk) disable iff (rst)
    !tick_i |=> $stable(cnt_q));
  // R3: a wrap leaves the count at zero with the flag raised
  assert_wrap_flag_R3: assert property (@(posedge clk) disable iff (rst)
    wrap_ev |=> (cnt_q == '0) && flag_q);
  // R3: without a clear the overflow count only holds or steps by one
  assert_ovf_step_R3: assert property (@(posedge clk) disable iff (rst)
    !clr_i |=> (ovf_q == $past(ovf_q)) || (ovf_q == OVF_W'($past(ovf_q) + 1'b1)));
  // R5: a clear without a wrap empties overflow count and flag
  assert_ack_clear_R5: assert property (@(posedge clk) disable iff (rst)
    (clr_i && !wrap_ev) |=> (ovf_q == '0) && !flag_q);
  // R8: once parked at zero with run off, it stays parked
  assert_parked_R8: assert property (@(posedge clk) disable iff (rst)
    (!run_i && cnt_q == '0) |=> (cnt_q == '0));
endmodule

// File: rtl/pit_regs.sv
module pit_regs
  import pit_pkg::*;
#(
  parameter int CNT_W  = 20,
  parameter int OVF_W  = 12,
  parameter int ADDR_W = 4
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   sel_i,
  input  logic                   wr_i,
  input  logic [ADDR_W-1:0]      addr_i,
  input  logic [CNT_W+OVF_W-1:0] wdata_i,
  input  logic [CNT_W-1:0]       cnt_i,
  input  logic [OVF_W-1:0]       ovf_i,
  input  logic                   flag_i,
  output logic [CNT_W+OVF_W-1:0] rdata_o,
  output logic                   run_o,
  output logic                   irqen_o,
  output logic [CNT_W-1:0]       limit_o,
  output logic                   clr_o
);
  localparam int DW = CNT_W + OVF_W;

  reg_sel_e         rsel;
  logic             rd_stb, wr_ctrl;
  logic [CNT_W-1:0] limit_q;
  logic             run_q, irqen_q;
  logic [DW-1:0]    ctrl_word, rd_mux, rdata_q;

  always_comb begin
    rsel    = reg_sel_e'(addr_i[3:2]);
    rd_stb  = sel_i && !wr_i;
    wr_ctrl = sel_i && wr_i && (rsel == REG_CTRL);
    ctrl_word = '0;
    ctrl_word[CNT_W-1:0] = limit_q;
    ctrl_word[RUN_BIT]   = run_q;
    ctrl_word[IRQEN_BIT] = irqen_q;
    case (rsel)
      REG_CTRL: rd_mux = ctrl_word;
      REG_STAT: rd_mux = DW'(flag_i);
      default:  rd_mux = {ovf_i, cnt_i};
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      limit_q <= '0;
      run_q   <= 1'b0;
      irqen_q <= 1'b0;
      rdata_q <= '0;
    end else begin
      if (wr_ctrl) begin
        limit_q <= wdata_i[CNT_W-1:0];
        run_q   <= wdata_i[RUN_BIT];
        irqen_q <= wdata_i[IRQEN_BIT];
      end
      if (rd_stb) rdata_q <= rd_mux;
    end
  end

  assign rdata_o = rdata_q;
  assign run_o   = run_q;
  assign irqen_o = irqen_q;
  assign limit_o = limit_q;
  assign clr_o   = rd_stb && (rsel == REG_ACKV);

  // R11: read data holds between reads
  assert_rdata_hold_R11: assert property (@(posedge clk) disable iff (rst)
    !(sel_i && !wr_i) |=> $stable(rdata_q));
  // R10: the control word changes only on a write
  assert_ctrl_hold_R10: assert property (@(posedge clk) disable iff (rst)
    !(sel_i && wr_i) |=> $stable(limit_q) && $stable(run_q) && $stable(irqen_q));
endmodule

// File: rtl/interval_timer.sv
module interval_timer #(
  parameter int CNT_W     = 20,
  parameter int OVF_W     = 12,
  parameter int PRESC_DIV = 16,
  parameter int ADDR_W    = 4
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   bus_sel,
  input  logic                   bus_wr,
  input  logic [ADDR_W-1:0]      bus_addr,
  input  logic [CNT_W+OVF_W-1:0] bus_wdata,
  output logic [CNT_W+OVF_W-1:0] bus_rdata,
  output logic                   irq
);
  logic             tick, run, irqen, clr, flag;
  logic [CNT_W-1:0] limit, cnt;
  logic [OVF_W-1:0] ovf;

  pit_prescaler #(.DIV(PRESC_DIV)) u_presc (
    .clk(clk), .rst(rst), .tick_o(tick)
  );

  pit_counter #(.CNT_W(CNT_W), .OVF_W(OVF_W)) u_cnt (
    .clk(clk), .rst(rst), .tick_i(tick), .run_i(run), .limit_i(limit),
    .clr_i(clr), .cnt_o(cnt), .ovf_o(ovf), .flag_o(flag)
  );

  pit_regs #(.CNT_W(CNT_W), .OVF_W(OVF_W), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst(rst), .sel_i(bus_sel), .wr_i(bus_wr), .addr_i(bus_addr),
    .wdata_i(bus_wdata), .cnt_i(cnt), .ovf_i(ovf), .flag_i(flag),
    .rdata_o(bus_rdata), .run_o(run), .irqen_o(irqen), .limit_o(limit),
    .clr_o(clr)
  );

  assign irq = flag && irqen;

  // R9: with interrupts disabled the line stays low
  assert_irq_gate_R9: assert property (@(posedge clk) disable iff (rst)
    !irqen |-> !irq);
endmodule

// File: tb/sim_interval_timer.sv
module sim_interval_timer;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_sel = 1'b0, bus_wr = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq;

  int n_tests = 0, n_fail = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  interval_timer u0 (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq(irq)
  );

  function automatic logic [31:0] ctrl_mask(input logic [31:0] w);
    return w & 32'h030F_FFFF;
  endfunction

  function automatic logic [31:0] pack_word(input logic [11:0] o, input logic [19:0] c);
    return {o, c};
  endfunction

  // cycle model of the requirements
  logic [3:0]  m_pre;
  logic [19:0] m_cnt, m_hlim;
  logic [11:0] m_ovf;
  logic        m_flag;
  logic [31:0] m_ctrl, m_rd;

  always @(posedge clk) begin : model
    logic rd, clr, tk, en, act, wrap;
    logic [19:0] lim;
    if (rst) begin
      m_pre <= '0; m_cnt <= '0; m_hlim <= '0; m_ovf <= '0;
      m_flag <= 1'b0; m_ctrl <= '0; m_rd <= '0;
    end else begin
      rd   = bus_sel && !bus_wr;
      clr  = rd && (bus_addr[3:2] == 2'd2);
      tk   = (m_pre == 4'd15);
      en   = m_ctrl[24];
      lim  = en ? m_ctrl[19:0] : m_hlim;
      act  = en || (m_cnt != 0);
      wrap = tk && act && (m_cnt >= lim);
      if (rd) begin
        case (bus_addr[3:2])
          2'd0: m_rd <= m_ctrl;
          2'd1: m_rd <= {31'd0, m_flag};
          default: m_rd <= pack_word(m_ovf, m_cnt);
        endcase
      end
      m_pre <= m_pre + 1'b1;
      if (en) m_hlim <= m_ctrl[19:0];
      if (tk && act) m_cnt <= wrap ? 20'd0 : m_cnt + 1'b1;
      if (clr) m_ovf <= wrap ? 12'd1 : 12'd0;
      else if (wrap) m_ovf <= m_ovf + 1'b1;
      if (wrap) m_flag <= 1'b1;
      else if (clr) m_flag <= 1'b0;
      if (bus_sel && bus_wr && bus_addr[3:2] == 2'd0) m_ctrl <= ctrl_mask(bus_wdata);
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic bus_write(input logic [3:0] a, input logic [31:0] d);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [3:0] a, input string req, output logic [31:0] got);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_sel = 1'b0;
    got = bus_rdata;
    check(req, bus_rdata, m_rd);
    check("R9 irq", {31'd0, irq}, {31'd0, m_flag & m_ctrl[25]});
  endtask

  task automatic finish_up;
    if (!finished) begin
      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(4 * 190000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_up();
  end

  initial begin
    logic [31:0] v, v2;
    void'($urandom(32'd4242));
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    bus_read(4'h0, "R1 ctrl", v);  check("R1 ctrl zero", v, 32'd0);
    bus_read(4'hC, "R1 snap", v);  check("R1 count zero", v, 32'd0);
    bus_read(4'h4, "R7 stat", v);  check("R1 flag zero", v, 32'd0);
    check("R1 irq low", {31'd0, irq}, 32'd0);

    // R2 tick rate: 160 cycles between reads give exactly 10 counts
    bus_write(4'h0, 32'h0100_0000 | 32'd1000);
    idle(50);
    bus_read(4'hC, "R4 snap", v);
    idle(159);
    bus_read(4'hC, "R4 snap", v2);
    check("R2 ten ticks", v2[19:0] - v[19:0], 32'd10);

    // R3 short period with interrupt
    bus_write(4'h0, 32'h0300_0000 | 32'd4);
    idle(200);
    bus_read(4'h4, "R7 stat", v);  check("R3 flag set", v, 32'd1);
    bus_read(4'hC, "R6 snap", v);
    bus_read(4'h4, "R6 stat kept", v2); check("R6 flag kept", v2, 32'd1);
    bus_read(4'h8, "R5 ack", v);
    bus_read(4'h4, "R5 stat", v);

    // R10 writes to read-only offsets and control mask
    bus_write(4'h4, 32'hFFFF_FFFF);
    bus_write(4'h8, 32'hFFFF_FFFF);
    bus_write(4'hC, 32'hFFFF_FFFF);
    bus_read(4'h0, "R10 ctrl kept", v); check("R10 ctrl kept", v, 32'h0300_0004);
    bus_write(4'h0, 32'hFFFF_FFFF);
    bus_read(4'h0, "R10 mask", v); check("R10 mask", v, 32'h030F_FFFF);

    // R8 wind-down after run bit cleared
    bus_write(4'h0, 32'h0100_0000 | 32'd30);
    bus_read(4'h8, "R5 ack", v);
    idle(16 * 12);
    bus_write(4'h0, 32'd0);
    idle(16 * 40);
    bus_read(4'hC, "R8 parked", v); check("R8 count zero", {12'd0, v[19:0]}, 32'd0);
    bus_read(4'h4, "R8 stat", v);   check("R8 final wrap flagged", v, 32'd1);
    idle(300);
    bus_read(4'hC, "R8 still parked", v2); check("R8 hold", v2, v2 & 32'hFFF0_0000);

    // R9 counting with interrupt disabled, then enabled
    bus_write(4'h0, 32'h0100_0000 | 32'd2);
    idle(100);
    check("R9 irq gated", {31'd0, irq}, 32'd0);
    bus_write(4'h0, 32'h0300_0000 | 32'd2);
    idle(1);
    check("R9 irq raised", {31'd0, irq}, 32'd1);

    // R5 acknowledge reads on every cycle, some coincide with a wrap
    bus_write(4'h0, 32'h0300_0000);
    for (int i = 0; i < 48; i++) bus_read(4'h8, "R5 ack sweep", v);

    // R3 overflow count modulo 4096
    bus_read(4'h8, "R5 ack", v);
    idle(16 * 4100);
    bus_read(4'hC, "R3 ovf wrap", v);

    // random mix
    for (int i = 0; i < 400; i++) begin
      int op;
      op = $urandom % 4;
      case (op)
        0: bus_write(4'h0, ($urandom % 50) | (($urandom % 2) << 24) | (($urandom % 2) << 25));
        1: idle($urandom % 60);
        default: bus_read(4'((($urandom % 4)) << 2), "R4 random read", v);
      endcase
    end

    finish_up();
  end
endmodule